// File: doc/BRIEF.md
# HDLC Transmit Bit-Stream Framer

This block turns a stream of packet bytes, taken from the read side of a byte FIFO, into a serial HDLC line signal. It sends one line bit per clock. Each packet starts with an opening flag and ends with a closing flag. Data and checksum bits are zero-stuffed so that no flag can appear inside a packet. When enabled, a 16-bit frame check sequence is added after the last data byte. Between packets the line carries either continuous ones or back-to-back flags.

The FIFO is read with a show-ahead handshake. While `fifo_empty` is low, `fifo_data` and `fifo_eop` describe the head entry. A one-cycle `fifo_rd` removes that entry. The FIFO itself and the register access to it are outside this block.

Four static controls set the behaviour:
- the kind of idle fill,
- checksum generation,
- the bit order inside a byte,
- inversion of the whole line signal.

If the FIFO runs dry before the byte that ends a packet, the packet is aborted on the line and a one-cycle `underflow` pulse is raised.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With `cfg_flag_idle`=0 and no packet pending, the line (before inversion) is continuously 1. With `cfg_flag_idle`=1 it carries repeated flags of value 0x7E, that is the bit pattern 0,1,1,1,1,1,1,0.
- R2: Every packet is sent as one 0x7E opening flag, then its bytes, then the checksum if enabled, then one 0x7E closing flag. Flags are never bit-stuffed.
- R3: Inside a packet, after every run of five consecutive 1 bits of data or checksum, a single 0 bit is inserted. This also applies when the run ends at a byte boundary or at the last bit before the closing flag.
- R4: Each byte is sent most significant bit (bit 7) first when `cfg_lsb_first`=0, and least significant bit (bit 0) first when `cfg_lsb_first`=1.
- R5: With `cfg_fcs_en`=1, 16 bits follow the last data byte. They are the ones complement of a CRC register with preset 0xFFFF, updated once per transmitted data bit in line order using the reflected polynomial 0x8408 (feedback = bit XOR reg[0]; reg shifts right; on feedback, XOR 0x8408). They are sent reg bit 0 first. With `cfg_fcs_en`=0, the closing flag directly follows the last data byte.
- R6: With `cfg_invert`=1, every line bit (idle fill, flags, inserted zeros, data, checksum and abort) is the complement of the bit sent with `cfg_invert`=0.
- R7: `fifo_rd` is high for exactly one cycle per byte taken. It is never high while `fifo_empty` is high. The entry whose `fifo_eop`=1 is the final byte of its packet.
- R8: If the FIFO is empty when the byte after a non-final byte is needed, the block sends eight 1 bits with no closing flag, pulses `underflow` high for exactly one cycle, and then returns to idle fill. Every byte already taken stays consumed.
- R9: With `cfg_flag_idle`=1, at least one idle flag is sent between the closing flag of one packet and the opening flag of the next, even when the next packet is already waiting.
- R10: While `rst_n` is low with `cfg_invert`=0, `line_bit` is 1 and `fifo_rd` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag_idle | input | 1 | 1: flags between packets, 0: all ones |
| cfg_fcs_en | input | 1 | 1: append the 16-bit checksum |
| cfg_lsb_first | input | 1 | 1: send bit 0 of each byte first |
| cfg_invert | input | 1 | 1: complement the whole line signal |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_eop | input | 1 | Head byte ends its packet |
| fifo_rd | output | 1 | Pop the head entry this cycle |
| line_bit | output | 1 | Serial HDLC output |
| underflow | output | 1 | One-cycle pulse when a packet is aborted for lack of data |

## Verification
Bit stuffing can fall in the same cycle as a byte boundary. A pending inserted zero has to go out in the very cycle where the block would otherwise read the next byte, start the checksum, start the closing flag, or decide on an underflow abort. The bench provokes this with bytes whose last five bits are ones (0x1F, 0xFF, 0xF8 in reversed order), placed in the middle of a packet, at its end with and without the checksum, and just before the FIFO runs dry. A scoreboard receiver in the bench removes stuffing, finds flags and aborts, and compares every recovered byte and checksum against the queued packets. An inserted zero that is lost or doubled at such a boundary therefore shows up as a wrong length, a wrong byte or a wrong checksum.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   // Transmit sequencer states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_OPEN  = 3'd1,
      ST_DATA  = 3'd2,
      ST_FCS   = 3'd3,
      ST_CLOSE = 3'd4,
      ST_ABORT = 3'd5
   } tx_state_e;

   // Flag octet; the pattern is symmetric, so bit order does not matter
   localparam logic [7:0] FLAG_PAT = 8'h7E;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic emit_valid,   // a stuffable bit went out this cycle
   input  logic emit_bit,
   output logic stuff_now     // the next line bit must be an inserted zero
);
   localparam int CNT_W = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

   logic [CNT_W-1:0] run_q;

   assign stuff_now = (run_q == RUN_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)                     run_q <= '0;
      else if (stuff_now)             run_q <= '0;
      else if (emit_valid && emit_bit) run_q <= run_q + 1'b1;
      else                            run_q <= '0;
   end
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
   parameter int               FCS_W = 16,
   parameter logic [FCS_W-1:0] POLY  = 16'h8408,
   parameter logic [FCS_W-1:0] INIT  = 16'hFFFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic step,
   input  logic shift,
   input  logic din,
   output logic fcs_bit
);
   logic [FCS_W-1:0] crc_q, crc_step;
   logic             fb;

   always_comb begin
      fb       = din ^ crc_q[0];
      crc_step = {1'b0, crc_q[FCS_W-1:1]};
      if (fb) crc_step = crc_step ^ POLY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= INIT;
      else if (init)  crc_q <= INIT;
      else if (step)  crc_q <= crc_step;
      else if (shift) crc_q <= {1'b0, crc_q[FCS_W-1:1]};
   end

   assign fcs_bit = ~crc_q[0];
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
   import hdlc_tx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int FCS_W     = 16,
   parameter int ABORT_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_flag_idle,
   input  logic              cfg_fcs_en,
   input  logic              cfg_lsb_first,
   input  logic              fifo_empty,
   input  logic [BYTE_W-1:0] fifo_data,
   input  logic              fifo_eop,
   output logic              fifo_rd,
   input  logic              stuff_now,
   input  logic              fcs_bit,
   output logic              fcs_init,
   output logic              fcs_step,
   output logic              fcs_shift,
   output logic              raw_bit,
   output logic              emit_valid,
   output logic              uflow_evt,
   output tx_state_e         state
);
   localparam int UNIT_MAX = max3(BYTE_W, FCS_W, ABORT_LEN);
   localparam int IDX_W    = $clog2(UNIT_MAX);
   localparam int BIDX_W   = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] BYTE_LAST  = IDX_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] FCS_LAST   = IDX_W'(FCS_W - 1);
   localparam logic [IDX_W-1:0] ABORT_LAST = IDX_W'(ABORT_LEN - 1);

   tx_state_e         st_q, st_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [BYTE_W-1:0] sh_q, sh_d;
   logic              eop_q, eop_d;
   logic [BYTE_W-1:0] data_rev, data_in;
   logic              flag_bit, byte_end;

   // Byte reversal for least-significant-bit-first transmission
   for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
      assign data_rev[g] = fifo_data[BYTE_W-1-g];
   end
   assign data_in  = cfg_lsb_first ? data_rev : fifo_data;
   assign flag_bit = FLAG_PAT[idx_q[BIDX_W-1:0]];
   assign byte_end = (idx_q == BYTE_LAST);

   always_comb begin
      st_d       = st_q;
      idx_d      = idx_q;
      sh_d       = sh_q;
      eop_d      = eop_q;
      raw_bit    = 1'b1;
      fifo_rd    = 1'b0;
      uflow_evt  = 1'b0;
      fcs_init   = 1'b0;
      fcs_step   = 1'b0;
      fcs_shift  = 1'b0;
      emit_valid = 1'b0;
      if (stuff_now) begin
         raw_bit = 1'b0;                 // inserted zero; sequencer holds
      end else begin
         idx_d = idx_q + 1'b1;
         unique case (st_q)
            ST_IDLE: begin
               raw_bit = cfg_flag_idle ? flag_bit : 1'b1;
               if (byte_end) begin
                  idx_d = '0;
                  if (!fifo_empty) st_d = ST_OPEN;
               end
            end
            ST_OPEN: begin
               raw_bit = flag_bit;
               if (byte_end) begin
                  idx_d    = '0;
                  fifo_rd  = 1'b1;
                  sh_d     = data_in;
                  eop_d    = fifo_eop;
                  fcs_init = 1'b1;
                  st_d     = ST_DATA;
               end
            end
            ST_DATA: begin
               raw_bit    = sh_q[BYTE_W-1];
               emit_valid = 1'b1;
               fcs_step   = 1'b1;
               sh_d       = {sh_q[BYTE_W-2:0], 1'b0};
               if (byte_end) begin
                  idx_d = '0;
                  if (eop_q) begin
                     st_d = cfg_fcs_en ? ST_FCS : ST_CLOSE;
                  end else if (fifo_empty) begin
                     st_d      = ST_ABORT;
                     uflow_evt = 1'b1;
                  end else begin
                     fifo_rd = 1'b1;
                     sh_d    = data_in;
                     eop_d   = fifo_eop;
                  end
               end
            end
            ST_FCS: begin
               raw_bit    = fcs_bit;
               emit_valid = 1'b1;
               fcs_shift  = 1'b1;
               if (idx_q == FCS_LAST) begin
                  idx_d = '0;
                  st_d  = ST_CLOSE;
               end
            end
            ST_CLOSE: begin
               raw_bit = flag_bit;
               if (byte_end) begin
                  idx_d = '0;
                  st_d  = ST_IDLE;
               end
            end
            ST_ABORT: begin
               raw_bit = 1'b1;
               if (idx_q == ABORT_LAST) begin
                  idx_d = '0;
                  st_d  = ST_IDLE;
               end
            end
            default: begin
               idx_d = '0;
               st_d  = ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         sh_q  <= '0;
         eop_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         sh_q  <= sh_d;
         eop_q <= eop_d;
      end
   end

   assign state = st_q;

   AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !fifo_rd);                                  // R7
   AST_ABORT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ABORT) |-> (!fifo_rd && raw_bit == !stuff_now));      // R8
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int               BYTE_W    = 8,
   parameter int               FCS_W     = 16,
   parameter logic [FCS_W-1:0] FCS_POLY  = 16'h8408,
   parameter logic [FCS_W-1:0] FCS_INIT  = 16'hFFFF,
   parameter int               RUN_LEN   = 5,
   parameter int               ABORT_LEN = 8,
   parameter bit               OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_flag_idle,
   input  logic              cfg_fcs_en,
   input  logic              cfg_lsb_first,
   input  logic              cfg_invert,
   input  logic              fifo_empty,
   input  logic [BYTE_W-1:0] fifo_data,
   input  logic              fifo_eop,
   output logic              fifo_rd,
   output logic              line_bit,
   output logic              underflow
);
   // Elaboration-time parameter checks
   if (BYTE_W != 8) begin : g_chk_byte
      $error("hdlc_tx_framer: BYTE_W must be 8, flag octet is fixed");
   end
   if (FCS_W != 16) begin : g_chk_fcs
      $error("hdlc_tx_framer: FCS_W must be 16");
   end
   if (ABORT_LEN < 7) begin : g_chk_abort
      $error("hdlc_tx_framer: ABORT_LEN must be at least 7");
   end
   if (RUN_LEN < 1 || RUN_LEN > 6) begin : g_chk_run
      $error("hdlc_tx_framer: RUN_LEN out of range");
   end

   logic      stuff_now, fcs_bit, fcs_init, fcs_step, fcs_shift;
   logic      raw_bit, emit_valid, uflow_evt, line_pre, uflow_q;
   tx_state_e state;

   hdlc_tx_ctrl #(
      .BYTE_W(BYTE_W), .FCS_W(FCS_W), .ABORT_LEN(ABORT_LEN)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_flag_idle(cfg_flag_idle), .cfg_fcs_en(cfg_fcs_en),
      .cfg_lsb_first(cfg_lsb_first),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
      .fifo_rd(fifo_rd), .stuff_now(stuff_now), .fcs_bit(fcs_bit),
      .fcs_init(fcs_init), .fcs_step(fcs_step), .fcs_shift(fcs_shift),
      .raw_bit(raw_bit), .emit_valid(emit_valid), .uflow_evt(uflow_evt),
      .state(state)
   );

   hdlc_tx_stuffer #(.RUN_LEN(RUN_LEN)) stuff_i (
      .clk(clk), .rst_n(rst_n),
      .emit_valid(emit_valid), .emit_bit(raw_bit), .stuff_now(stuff_now)
   );

   hdlc_tx_fcs #(.FCS_W(FCS_W), .POLY(FCS_POLY), .INIT(FCS_INIT)) fcs_i (
      .clk(clk), .rst_n(rst_n),
      .init(fcs_init), .step(fcs_step), .shift(fcs_shift),
      .din(raw_bit), .fcs_bit(fcs_bit)
   );

   // Output stage variant
   if (OUT_REG) begin : g_oreg
      logic out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) out_q <= 1'b1;
         else        out_q <= raw_bit;
      end
      assign line_pre = out_q;

      AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         stuff_now |=> !line_pre);                                      // R3
   end else begin : g_ocomb
      assign line_pre = raw_bit;
   end

   assign line_bit = line_pre ^ cfg_invert;

   always_ff @(posedge clk) begin
      if (!rst_n) uflow_q <= 1'b0;
      else        uflow_q <= uflow_evt;
   end
   assign underflow = uflow_q;

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);                                         // R7
   AST_UFLOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (state == ST_ABORT));                               // R8
   AST_UFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> !underflow);                                        // R8
endmodule

// File: tb/hdlc_tx_framer_tb_top.sv
module hdlc_tx_framer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_flag_idle = 1'b0, cfg_fcs_en = 1'b0;
   logic       cfg_lsb_first = 1'b0, cfg_invert = 1'b0;
   logic       fifo_empty, fifo_eop, fifo_rd, line_bit, underflow;
   logic [7:0] fifo_data;

   logic [8:0]  mem [0:255];
   logic [31:0] rd_ptr = '0;
   logic [31:0] wr_ptr = '0;

   int n_chk = 0, n_err = 0;

   // Scoreboard queues and receiver state
   int         exp_len[$];
   bit         exp_abt[$];
   logic [7:0] exp_dat[$];
   logic [7:0] pkt[$];
   bit         fbits[$];
   bit         in_frame = 0, gap_seen = 0, mon_off = 1, rb, rdrop;
   logic [7:0] hist = '0;
   int         ones_run = 0, gap_flags = 0, flag_cnt = 0;
   int         uf_cnt = 0, bad_pop = 0;
   string      cur_tag = "R2";

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_tx_framer dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_flag_idle(cfg_flag_idle), .cfg_fcs_en(cfg_fcs_en),
      .cfg_lsb_first(cfg_lsb_first), .cfg_invert(cfg_invert),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
      .fifo_rd(fifo_rd), .line_bit(line_bit), .underflow(underflow)
   );

   // Show-ahead FIFO model
   assign fifo_empty = (rd_ptr == wr_ptr);
   assign {fifo_eop, fifo_data} = mem[rd_ptr[7:0]];
   always @(posedge clk) if (fifo_rd && !fifo_empty) rd_ptr <= rd_ptr + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: push bytes into the FIFO and the expectation queues
   task automatic send_pkt(input bit closes);
      foreach (pkt[i]) begin
         mem[wr_ptr[7:0]] = {closes && (i == pkt.size() - 1), pkt[i]};
         exp_dat.push_back(pkt[i]);
         wr_ptr = wr_ptr + 1;
      end
      exp_len.push_back(pkt.size());
      exp_abt.push_back(!closes);
   endtask

   task automatic drain();
      int t = 0;
      while (exp_len.size() != 0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk(exp_len.size() == 0, cur_tag, "packets still pending", exp_len.size(), 0);
      repeat (16) @(negedge clk);
   endtask

   task automatic set_cfg(input bit fi, input bit fe, input bit ls, input bit inv);
      mon_off = 1;
      cfg_flag_idle = fi; cfg_fcs_en = fe; cfg_lsb_first = ls; cfg_invert = inv;
      repeat (24) @(negedge clk);
      in_frame = 0; fbits.delete(); ones_run = 0; hist = '0;
      gap_seen = 0; gap_flags = 0;
      mon_off = 0;
   endtask

   task automatic frame_end();
      int n, dbits, len;
      bit abt, ok;
      logic [7:0] e, by;
      logic [15:0] c, got;
      n = fbits.size();
      dbits = n - (cfg_fcs_en ? 16 : 0);
      if (exp_len.size() == 0) begin
         chk(0, "R2", "unexpected frame, bits", n, 0);
         return;
      end
      len = exp_len.pop_front();
      abt = exp_abt.pop_front();
      chk(!abt, "R8", "frame closed where abort expected", 1, 0);
      chk(dbits == len * 8, cur_tag, "data bit count", dbits, len * 8);
      if (gap_seen && cfg_flag_idle)
         chk(gap_flags >= 2, "R9", "flags between packets", gap_flags, 2);
      for (int i = 0; i < len; i++) begin
         e = exp_dat.pop_front();
         if (dbits == len * 8) begin
            by = '0;
            for (int k = 0; k < 8; k++) begin
               if (cfg_lsb_first) by[k] = fbits[i*8+k];
               else               by[7-k] = fbits[i*8+k];
            end
            chk(by == e, cfg_lsb_first ? "R4" : cur_tag, "received byte", by, e);
         end
      end
      if (cfg_fcs_en && dbits == len * 8) begin
         c = 16'hFFFF;
         for (int i = 0; i < dbits; i++) begin
            ok = fbits[i] ^ c[0];
            c  = c >> 1;
            if (ok) c = c ^ 16'h8408;
         end
         for (int k = 0; k < 16; k++) got[k] = fbits[dbits+k];
         chk(got == ~c, "R5", "checksum", got, ~c);
      end
      gap_seen = 1;
      gap_flags = 0;
   endtask

   task automatic abort_end();
      int len;
      bit abt;
      if (exp_len.size() == 0) begin
         chk(0, "R8", "unexpected abort", 1, 0);
         return;
      end
      len = exp_len.pop_front();
      abt = exp_abt.pop_front();
      chk(abt, "R8", "abort where closed frame expected", 0, 1);
      for (int i = 0; i < len; i++) void'(exp_dat.pop_front());
      gap_seen = 0;
      gap_flags = 0;
   endtask

   // Monitor: HDLC receiver on the line output
   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_rd && fifo_empty) bad_pop++;
         if (underflow) uf_cnt++;
      end
      if (rst_n && !mon_off) begin
         rb = line_bit ^ cfg_invert;
         rdrop = (rb == 1'b0 && ones_run == 5);
         ones_run = rb ? ones_run + 1 : 0;
         hist = {hist[6:0], rb};
         if (in_frame && !rdrop) fbits.push_back(rb);
         if (hist == 8'h7E) begin
            flag_cnt++;
            if (in_frame) begin
               if (fbits.size() >= 8) repeat (8) void'(fbits.pop_back());
               else fbits.delete();
               if (fbits.size() > 0) frame_end();
               else gap_flags++;
            end
            in_frame = 1;
            fbits.delete();
         end else if (ones_run >= 7 && in_frame) begin
            if (fbits.size() >= 15) abort_end();
            in_frame = 0;
            fbits.delete();
         end
      end
   end

   initial begin
      int f0, u0, bad;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      chk(line_bit === 1'b1, "R10", "line during reset", line_bit, 1);
      chk(fifo_rd === 1'b0 && underflow === 1'b0, "R10", "rd/underflow in reset",
          {fifo_rd, underflow}, 0);
      rst_n = 1'b1;

      // R1: all-ones idle
      set_cfg(0, 1, 0, 0);
      bad = 0;
      repeat (24) begin @(negedge clk); if (line_bit !== 1'b1) bad++; end
      chk(bad == 0, "R1", "zeros seen in ones idle", bad, 0);

      // R1: flag idle
      set_cfg(1, 1, 0, 0);
      f0 = flag_cnt;
      repeat (48) @(negedge clk);
      chk(flag_cnt - f0 >= 5, "R1", "idle flags in 48 bits", flag_cnt - f0, 5);

      // R2 R3 R5: flag idle, checksum, stuffing around byte boundaries
      cur_tag = "R3";
      pkt = '{8'h12, 8'h7E, 8'hFF, 8'h1F, 8'h3C};
      send_pkt(1); drain();

      // R5 off: stuffed zero right before the closing flag
      set_cfg(1, 0, 0, 0);
      cur_tag = "R5";
      pkt = '{8'hA5, 8'h1F};
      send_pkt(1); drain();

      // R4: LSB first
      set_cfg(1, 1, 1, 0);
      pkt = '{8'h01, 8'h80, 8'hF8, 8'h5A};
      send_pkt(1); drain();

      // R9: back-to-back packets in flag idle
      set_cfg(1, 1, 0, 0);
      cur_tag = "R9";
      pkt = '{8'hC3, 8'hFF};
      send_pkt(1);
      pkt = '{8'h00};
      send_pkt(1);
      pkt = '{8'h7F, 8'hFE};
      send_pkt(1);
      drain();

      // R8: underflow with a stuffed zero due at the byte boundary
      set_cfg(0, 1, 0, 0);
      cur_tag = "R8";
      u0 = uf_cnt;
      pkt = '{8'h00, 8'h1F};
      send_pkt(0); drain();
      chk(uf_cnt - u0 == 1, "R8", "underflow pulse cycles", uf_cnt - u0, 1);
      chk(rd_ptr == wr_ptr, "R8", "bytes left after abort", wr_ptr - rd_ptr, 0);
      pkt = '{8'h33};
      send_pkt(1); drain();

      // R6: inverted line, idle and packet
      set_cfg(0, 1, 0, 1);
      bad = 0;
      repeat (16) begin @(negedge clk); if (line_bit !== 1'b0) bad++; end
      chk(bad == 0, "R6", "inverted idle not low", bad, 0);
      cur_tag = "R6";
      pkt = '{8'h55, 8'hFF, 8'h0F};
      send_pkt(1); drain();

      // R7: FIFO handshake
      chk(rd_ptr == wr_ptr, "R7", "unread bytes", wr_ptr - rd_ptr, 0);
      chk(bad_pop == 0, "R7", "reads while empty", bad_pop, 0);
      chk(uf_cnt == 1, "R8", "total underflow pulses", uf_cnt, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule